// File: doc/BRIEF.md
# Token Steering Controller for a Ring-Buffer Cell

This block sits inside one cell of a FIFO built as a ring of identical storage cells, where two tokens travel around the ring. The put token picks the cell that accepts the next write. The get token picks the cell that supplies the next read. No data moves between cells. Each cell receives tokens one at a time from its upstream neighbour on a single four-phase channel. The same channel carries the put token and the get token in turn.

The controller takes each arriving token and lends it to a local sub-controller. The first token goes to the put side and the next one goes to the get side, alternating from then on. Once the sub-controller gives the token back, the controller forwards it downstream.

Forwarding uses an internal hand-off channel. A small join machine in the same module merges that channel with the downstream neighbour's four-phase request. It acknowledges both together, and only when both are asserted. All acknowledge inputs, and the downstream request, arrive from outside the cell's clock domain and pass through a configurable synchronizer before the state machines use them.

Top module: `token_steer_cell`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `tok_in_req` is 1 and `put_tok_req`, `get_tok_req` and `out_ack` are 0.
- R2: `tok_in_req` stays high until `tok_in_ack` is seen high, then falls. Once `tok_in_ack` is seen low again, exactly one of `put_tok_req`/`get_tok_req` rises.
- R3: `put_tok_req` stays high until `put_tok_ack` is seen high, then falls. Once `put_tok_ack` is seen low, the token is offered downstream on the internal hand-off channel.
- R4: `tok_in_req` rises again one clock edge after the downstream join has released its acknowledge (`out_ack` falls).
- R5: Tokens are lent alternately: the first after reset goes to the put side (`put_tok_req`), the next to the get side (`get_tok_req`), and so on without end.
- R6: `get_tok_req` follows the same rules as R3, using `get_tok_ack`.
- R7: `out_ack` rises only when `out_req` and the internal hand-off request are both high. It falls only once both are low. While no token is offered, a high `out_req` leaves `out_ack` low.
- R8: Acknowledge levels that the current state does not wait for have no effect. This covers `get_tok_ack` or `tok_in_ack` while a put lend is pending, and either lend acknowledge while `tok_in_req` is pending.
- R9: At most one of `tok_in_req`, `put_tok_req`, `get_tok_req` and the internal hand-off request is high at any time.
- R10: Every output responds to a change in an input level exactly `ACK_SYNC`+1 rising clock edges after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_in_req | output | 1 | Request for the next token from the upstream cell |
| tok_in_ack | input | 1 | Upstream acknowledge: a token has been delivered |
| put_tok_req | output | 1 | Lends the held token to the put sub-controller |
| put_tok_ack | input | 1 | Put sub-controller acknowledge |
| get_tok_req | output | 1 | Lends the held token to the get sub-controller |
| get_tok_ack | input | 1 | Get sub-controller acknowledge |
| out_req | input | 1 | Downstream cell's request for a token |
| out_ack | output | 1 | Joint acknowledge of the downstream request and the internal hand-off |

## Verification
An input level reaches an output `ACK_SYNC`+1 rising edges after it changes: `ACK_SYNC` edges in the synchronizer and one in the state register. For each step of a handshake, the bench changes the input at a falling edge. It then checks that the output has not moved one edge early and has moved exactly on the due edge, sampling at a falling edge.

Hand-off results have their own timing because they cross between the two internal machines, which share a clock. With `out_req` already high, `out_ack` rises `ACK_SYNC`+2 edges after the lend acknowledge falls. After `out_req` drops, `out_ack` falls `ACK_SYNC`+1 edges later, and `tok_in_req` returns one edge after that.

A final phase drives every partner with random delays and checks the lend order by polling with a bounded wait.

// File: rtl/token_steer_pkg.sv
package token_steer_pkg;

    typedef enum logic [2:0] {
        ST_ASK_IN   = 3'd0,
        ST_IN_DONE  = 3'd1,
        ST_ASK_LEND = 3'd2,
        ST_LEND_RET = 3'd3,
        ST_ASK_FWD  = 3'd4,
        ST_FWD_DONE = 3'd5
    } steer_st_e;

    typedef enum logic {
        SIDE_PUT = 1'b0,
        SIDE_GET = 1'b1
    } side_e;

    typedef struct packed {
        steer_st_e st;
        side_e     side;
        logic      in_req;
        logic      put_req;
        logic      get_req;
        logic      fwd_req;
    } steer_regs_t;

    typedef enum logic {
        JN_IDLE = 1'b0,
        JN_BUSY = 1'b1
    } join_st_e;

    typedef struct packed {
        join_st_e st;
        logic     ack;
    } join_regs_t;

    localparam int unsigned ASYNC_IN_W = 4;

endpackage

// File: rtl/token_steer_sync.sv
module token_steer_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [WIDTH-1:0] chain_q [STAGES];
            logic [WIDTH-1:0] chain_d [STAGES];

            always_comb begin
                chain_d[0] = async_i;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) begin
                        chain_q[i] <= '0;
                    end
                end else begin
                    for (int i = 0; i < STAGES; i++) begin
                        chain_q[i] <= chain_d[i];
                    end
                end
            end

            assign sync_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/token_steer_fsm.sv
module token_steer_fsm
    import token_steer_pkg::*;
#(
    parameter bit FIRST_IS_PUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_ack,
    input  logic put_ack,
    input  logic get_ack,
    input  logic fwd_ack,
    output logic in_req,
    output logic put_req,
    output logic get_req,
    output logic fwd_req
);

    localparam side_e RESET_SIDE = FIRST_IS_PUT ? SIDE_PUT : SIDE_GET;
    localparam steer_regs_t RESET_REGS = '{
        st:      ST_ASK_IN,
        side:    RESET_SIDE,
        in_req:  1'b1,
        put_req: 1'b0,
        get_req: 1'b0,
        fwd_req: 1'b0
    };

    steer_regs_t r_d, r_q;
    logic        lend_ack;

    always_comb begin
        r_d      = r_q;
        lend_ack = (r_q.side == SIDE_PUT) ? put_ack : get_ack;
        unique case (r_q.st)
            ST_ASK_IN: begin
                if (in_ack) begin
                    r_d.in_req = 1'b0;
                    r_d.st     = ST_IN_DONE;
                end
            end
            ST_IN_DONE: begin
                if (!in_ack) begin
                    r_d.put_req = (r_q.side == SIDE_PUT);
                    r_d.get_req = (r_q.side == SIDE_GET);
                    r_d.st      = ST_ASK_LEND;
                end
            end
            ST_ASK_LEND: begin
                if (lend_ack) begin
                    r_d.put_req = 1'b0;
                    r_d.get_req = 1'b0;
                    r_d.st      = ST_LEND_RET;
                end
            end
            ST_LEND_RET: begin
                if (!lend_ack) begin
                    r_d.fwd_req = 1'b1;
                    r_d.st      = ST_ASK_FWD;
                end
            end
            ST_ASK_FWD: begin
                if (fwd_ack) begin
                    r_d.fwd_req = 1'b0;
                    r_d.st      = ST_FWD_DONE;
                end
            end
            ST_FWD_DONE: begin
                if (!fwd_ack) begin
                    r_d.in_req = 1'b1;
                    r_d.side   = (r_q.side == SIDE_PUT) ? SIDE_GET : SIDE_PUT;
                    r_d.st     = ST_ASK_IN;
                end
            end
            default: r_d = RESET_REGS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RESET_REGS;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_req  = r_q.in_req;
    assign put_req = r_q.put_req;
    assign get_req = r_q.get_req;
    assign fwd_req = r_q.fwd_req;

endmodule

// File: rtl/token_steer_join.sv
module token_steer_join
    import token_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic down_req,
    input  logic fwd_req,
    output logic joint_ack
);

    join_regs_t j_d, j_q;

    always_comb begin
        j_d = j_q;
        unique case (j_q.st)
            JN_IDLE: begin
                if (down_req && fwd_req) begin
                    j_d.st  = JN_BUSY;
                    j_d.ack = 1'b1;
                end
            end
            JN_BUSY: begin
                if (!down_req && !fwd_req) begin
                    j_d.st  = JN_IDLE;
                    j_d.ack = 1'b0;
                end
            end
            default: j_d = '{st: JN_IDLE, ack: 1'b0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            j_q <= '{st: JN_IDLE, ack: 1'b0};
        end else begin
            j_q <= j_d;
        end
    end

    assign joint_ack = j_q.ack;

endmodule

// File: rtl/token_steer_cell.sv
module token_steer_cell
    import token_steer_pkg::*;
#(
    parameter int unsigned ACK_SYNC     = 2,
    parameter bit          FIRST_IS_PUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tok_in_req,
    input  logic tok_in_ack,
    output logic put_tok_req,
    input  logic put_tok_ack,
    output logic get_tok_req,
    input  logic get_tok_ack,
    input  logic out_req,
    output logic out_ack
);

    logic [ASYNC_IN_W-1:0] raw_in;
    logic [ASYNC_IN_W-1:0] syn_in;
    logic                  in_ack_s;
    logic                  put_ack_s;
    logic                  get_ack_s;
    logic                  out_req_s;
    logic                  fwd_req;
    logic                  fwd_ack;

    assign raw_in = {tok_in_ack, put_tok_ack, get_tok_ack, out_req};

    token_steer_sync #(
        .WIDTH  (ASYNC_IN_W),
        .STAGES (ACK_SYNC)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    assign {in_ack_s, put_ack_s, get_ack_s, out_req_s} = syn_in;

    token_steer_fsm #(
        .FIRST_IS_PUT (FIRST_IS_PUT)
    ) u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_ack  (in_ack_s),
        .put_ack (put_ack_s),
        .get_ack (get_ack_s),
        .fwd_ack (fwd_ack),
        .in_req  (tok_in_req),
        .put_req (put_tok_req),
        .get_req (get_tok_req),
        .fwd_req (fwd_req)
    );

    token_steer_join u_join (
        .clk       (clk),
        .rst_n     (rst_n),
        .down_req  (out_req_s),
        .fwd_req   (fwd_req),
        .joint_ack (fwd_ack)
    );

    assign out_ack = fwd_ack;

endmodule

// File: rtl/token_steer_cell_chk.sv
module token_steer_cell_chk #(
    parameter bit FIRST_IS_PUT = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic in_req,
    input logic put_req,
    input logic get_req,
    input logic fwd_req,
    input logic fwd_ack,
    input logic in_ack_s,
    input logic put_ack_s,
    input logic get_ack_s,
    input logic out_req_s
);

    logic nxt_put_q;
    logic put_p_q;
    logic get_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_put_q <= FIRST_IS_PUT;
            put_p_q   <= 1'b0;
            get_p_q   <= 1'b0;
        end else begin
            put_p_q <= put_req;
            get_p_q <= get_req;
            if (put_req && !put_p_q) begin
                nxt_put_q <= 1'b0;
            end else if (get_req && !get_p_q) begin
                nxt_put_q <= 1'b1;
            end
        end
    end

    p_one_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_req, put_req, get_req, fwd_req}));

    p_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_req && !in_ack_s |=> in_req);

    p_in_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_req && in_ack_s |=> !in_req);

    p_put_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        put_req && put_ack_s |=> !put_req);

    p_put_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        put_req && !put_ack_s |=> put_req);

    p_get_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        get_req && get_ack_s |=> !get_req);

    p_get_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        get_req && !get_ack_s |=> get_req);

    p_put_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        put_req && !put_p_q |-> nxt_put_q);

    p_get_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        get_req && !get_p_q |-> !nxt_put_q);

    p_join_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_ack) |-> $past(out_req_s && fwd_req));

    p_join_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fwd_ack) |-> $past(!out_req_s && !fwd_req));

    p_reask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_req) |-> $past(!fwd_ack && !fwd_req));

endmodule

bind token_steer_cell token_steer_cell_chk #(
    .FIRST_IS_PUT (FIRST_IS_PUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_req    (tok_in_req),
    .put_req   (put_tok_req),
    .get_req   (get_tok_req),
    .fwd_req   (fwd_req),
    .fwd_ack   (fwd_ack),
    .in_ack_s  (in_ack_s),
    .put_ack_s (put_ack_s),
    .get_ack_s (get_ack_s),
    .out_req_s (out_req_s)
);

// File: tb/sim_token_steer_cell.sv
`timescale 1ns/1ps
module sim_token_steer_cell;

    localparam int unsigned SYNC = 2;
    localparam int unsigned LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_in_req, put_tok_req, get_tok_req, out_ack;
    logic tok_in_ack = 1'b0;
    logic put_tok_ack = 1'b0;
    logic get_tok_ack = 1'b0;
    logic out_req = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    token_steer_cell #(.ACK_SYNC(SYNC), .FIRST_IS_PUT(1'b1)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok_in_req  (tok_in_req),
        .tok_in_ack  (tok_in_ack),
        .put_tok_req (put_tok_req),
        .put_tok_ack (put_tok_ack),
        .get_tok_req (get_tok_req),
        .get_tok_ack (get_tok_ack),
        .out_req     (out_req),
        .out_ack     (out_ack)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic sig(input int sel);
        case (sel)
            0: return tok_in_req;
            1: return put_tok_req;
            2: return get_tok_req;
            default: return out_ack;
        endcase
    endfunction

    // poll with bounded wait; counts as one check
    task automatic wait_for(input int sel, input logic val, input string tag);
        int k = 0;
        while (sig(sel) !== val && k < 100) begin
            step(1);
            k++;
        end
        chk(tag, sig(sel), val);
    endtask

    task automatic t_reset;
        chk("R1 in_req during reset", tok_in_req, 1'b1);
        chk("R1 put_req during reset", put_tok_req, 1'b0);
        chk("R1 get_req during reset", get_tok_req, 1'b0);
        chk("R1 out_ack during reset", out_ack, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1 in_req after release", tok_in_req, 1'b1);
        chk("R1 lend idle after release", put_tok_req | get_tok_req, 1'b0);
    endtask

    // one full token cycle with exact timing checks
    task automatic t_token(input bit is_put, input bit down_ready, input bit inject);
        out_req = down_ready;
        step(LAT + 1);
        chk("R4 in_req pending at start", tok_in_req, 1'b1);
        chk("R7 no ack without token", out_ack, 1'b0);
        if (inject) begin
            put_tok_ack = 1'b1;
            get_tok_ack = 1'b1;
            step(LAT + 3);
            chk("R8 in_req kept despite lend acks", tok_in_req, 1'b1);
            chk("R8 no lend from stray acks", put_tok_req | get_tok_req, 1'b0);
            put_tok_ack = 1'b0;
            get_tok_ack = 1'b0;
            step(LAT + 1);
        end
        tok_in_ack = 1'b1;
        step(LAT - 1);
        chk("R10 in_req not early", tok_in_req, 1'b1);
        step(1);
        chk("R2 in_req falls", tok_in_req, 1'b0);
        tok_in_ack = 1'b0;
        step(LAT - 1);
        chk("R10 lend not early", put_tok_req | get_tok_req, 1'b0);
        step(1);
        chk("R5 put side chosen", put_tok_req, is_put);
        chk("R5 get side chosen", get_tok_req, !is_put);
        if (inject) begin
            if (is_put) get_tok_ack = 1'b1; else put_tok_ack = 1'b1;
            tok_in_ack = 1'b1;
            step(LAT + 3);
            chk("R8 lend held despite stray acks", put_tok_req | get_tok_req, 1'b1);
            chk("R8 in_req stays low", tok_in_req, 1'b0);
            get_tok_ack = 1'b0;
            put_tok_ack = 1'b0;
            tok_in_ack  = 1'b0;
            step(LAT + 1);
        end
        if (is_put) put_tok_ack = 1'b1; else get_tok_ack = 1'b1;
        step(LAT);
        chk(is_put ? "R3 put_req falls" : "R6 get_req falls", put_tok_req | get_tok_req, 1'b0);
        put_tok_ack = 1'b0;
        get_tok_ack = 1'b0;
        if (down_ready) begin
            step(LAT);
            chk("R10 out_ack not early", out_ack, 1'b0);
            step(1);
            chk(is_put ? "R3 hand-off acked" : "R6 hand-off acked", out_ack, 1'b1);
        end else begin
            step(LAT + 6);
            chk("R7 out_ack waits for out_req", out_ack, 1'b0);
            chk("R7 in_req waits for hand-off", tok_in_req, 1'b0);
            out_req = 1'b1;
            step(LAT);
            chk("R7 out_ack after out_req", out_ack, 1'b1);
        end
        out_req = 1'b0;
        step(LAT - 1);
        chk("R7 out_ack held", out_ack, 1'b1);
        step(1);
        chk("R7 out_ack released", out_ack, 1'b0);
        chk("R4 in_req not early", tok_in_req, 1'b0);
        step(1);
        chk("R4 in_req re-raised", tok_in_req, 1'b1);
    endtask

    // partners answer with random delays; order of lends is checked
    task automatic t_random(input int n_tok, input bit first_put);
        bit exp_put = first_put;
        for (int t = 0; t < n_tok; t++) begin
            wait_for(0, 1'b1, "R4 in_req (random)");
            step($urandom_range(0, 4));
            tok_in_ack = 1'b1;
            wait_for(0, 1'b0, "R2 in_req drop (random)");
            step($urandom_range(0, 4));
            tok_in_ack = 1'b0;
            step(LAT);
            chk("R5 put side (random)", put_tok_req, exp_put);
            chk("R5 get side (random)", get_tok_req, !exp_put);
            step($urandom_range(0, 4));
            if (exp_put) put_tok_ack = 1'b1; else get_tok_ack = 1'b1;
            wait_for(exp_put ? 1 : 2, 1'b0, "R3 lend drop (random)");
            step($urandom_range(0, 4));
            put_tok_ack = 1'b0;
            get_tok_ack = 1'b0;
            step($urandom_range(0, 6));
            out_req = 1'b1;
            wait_for(3, 1'b1, "R7 join ack (random)");
            step($urandom_range(0, 4));
            out_req = 1'b0;
            wait_for(3, 1'b0, "R7 join release (random)");
            exp_put = !exp_put;
        end
    endtask

    initial begin
        step(3);
        t_reset();
        t_token(1'b1, 1'b1, 1'b0);
        t_token(1'b0, 1'b1, 1'b0);
        t_token(1'b1, 1'b0, 1'b0);
        t_token(1'b0, 1'b0, 1'b1);
        t_token(1'b1, 1'b1, 1'b1);
        t_random(40, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule